// File: doc/BRIEF.md
# Four-Tributary Justified Bit Multiplexer

This block builds a 1056-bit aggregate frame out of four 2048 kbit/s tributaries. It interleaves one bit at a time from each tributary in the order 1, 2, 3, 4. It adds an alignment word, service bits, spare bits and justification control bits. It can drop one bit from a tributary (positive justification) or carry one extra bit (negative justification) in the last quarter of the frame. This lets each tributary run slightly slower or faster than its nominal 256 bits per frame.

The frame has four sets of 264 bits. One aggregate bit is produced per clock. Each tributary source shows its next bit on a port. The block takes that bit in the same cycle and pulses that tributary's read strobe. Justification requests are latched once per two-frame command period. The control bits carry the command in both frames of the period, and the stuffing itself takes place in the fourth set of the second frame.

Top module: `quad_trib_mux`

## Requirements
- R1: `frame_start` is 1 on frame bit 1 (set I, bit 1) and 0 elsewhere, so it repeats every 1056 cycles. Frames alternate between the first and second frame of a command period, and the first frame after reset is a first frame.
- R2: Bits 1 to 8 of set I carry 1,1,1,0,0,1,1,0, in that order.
- R3: Bit n of a set, for n from 9 to 264 and outside the set IV opportunity bits, carries data of tributary ((n-9) mod 4)+1.
- R4: Bits 1 to 4 of sets II, III and IV carry the control bit of tributaries 1 to 4. In the first frame of a period it is 0 for a negative command and 1 otherwise. In the second frame it is 1 for a positive command and 0 otherwise.
- R5: Bits 5 to 8 of set II carry `svc_bits[0..3]`, and bits 5 to 8 of set III carry `spare_bits[0..3]`.
- R6: Tributary t has a request field `just_req[2t+1:2t]`, with t = 0 to 3 for tributaries 1 to 4. The code 01 means positive, 10 means negative, and 00 or 11 means none. The field is sampled only in the clock that ends the first bit of a period's first frame. Changes at any other time have no effect on that period.
- R7: Set IV bit 9+t carries data of tributary t+1. In the second frame of a positive command, that bit is 0 instead and no read takes place.
- R8: Set IV bit 5+t is 0 with no read. In the second frame of a negative command, it carries data of tributary t+1 instead.
- R9: At most one read strobe is high in a cycle, and only on a bit that carries that tributary's data, which is the bit output in that cycle. Each tributary is read 256 times per frame, 255 times in a positive second frame and 257 times in a negative second frame.
- R10: While reset is low, the block sits at frame bit 1 of a first frame with no command latched. It shows `frame_start`=1, `agg_bit`=1 and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trib_bit | input | 4 | Next data bit of each tributary |
| trib_rd | output | 4 | Read strobe per tributary; the bit is consumed in this cycle |
| just_req | input | 8 | Two-bit justification request per tributary |
| svc_bits | input | 4 | Service bits for set II |
| spare_bits | input | 4 | Spare bits for set III |
| agg_bit | output | 1 | Aggregate serial bit |
| frame_start | output | 1 | High on the first bit of each frame |

## Verification
Two things meet in the second frame of a period, in set IV:
- the stuffing decision, which was latched a whole frame earlier;
- a request input that may have changed since then.

The bench sets a positive request and holds it through the sampling point. It then switches the request to negative twenty bits into the period. It expects the positive pattern throughout: control bits 1 then 1, a zero positive-opportunity bit, and exactly 255 reads per tributary. A mixed pattern of positive, negative, none and the unused code, one per tributary, checks that each tributary's opportunity bits follow only its own command within the same set.

// File: rtl/quad_trib_mux.sv
module quad_trib_mux #(
  parameter int SET_LEN = 264,
  parameter int NSET = 4,
  parameter int NTRIB = 4,
  parameter int HDR = 8,
  parameter logic [7:0] FAW = 8'b11100110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIB-1:0] trib_bit,
  output logic [NTRIB-1:0] trib_rd,
  input  logic [2*NTRIB-1:0] just_req,
  input  logic [NTRIB-1:0] svc_bits,
  input  logic [NTRIB-1:0] spare_bits,
  output logic             agg_bit,
  output logic             frame_start
);
  localparam int IW = $clog2(SET_LEN);
  localparam int SW = $clog2(NSET);
  localparam int TW = $clog2(NTRIB);
  localparam int HW = $clog2(HDR);
  localparam logic [IW-1:0] L_LAST = IW'(SET_LEN - 1);
  localparam logic [IW-1:0] L_HDR  = IW'(HDR);
  localparam logic [IW-1:0] L_NT   = IW'(NTRIB);
  localparam logic [IW-1:0] L_POSE = IW'(HDR + NTRIB);
  localparam logic [SW-1:0] S_LAST = SW'(NSET - 1);

  logic [IW-1:0] idx_q;
  logic [SW-1:0] set_q;
  logic          par_q;
  logic [2*NTRIB-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      set_q <= '0;
      par_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (frame_start && !par_q) cmd_q <= just_req;
      if (idx_q == L_LAST) begin
        idx_q <= '0;
        set_q <= set_q + 1'b1;
        if (set_q == S_LAST) par_q <= ~par_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign frame_start = (set_q == '0) && (idx_q == '0);

  logic [TW-1:0] tsel;
  logic [1:0]    code;
  logic          is_pos, is_neg;
  logic [IW-1:0] faw_i;
  assign tsel   = idx_q[TW-1:0];
  assign code   = cmd_q[2*tsel +: 2];
  assign is_pos = code == 2'b01;
  assign is_neg = code == 2'b10;
  assign faw_i  = IW'(HDR - 1) - idx_q;

  logic take;
  always_comb begin
    take = 1'b0;
    agg_bit = 1'b0;
    if (set_q == '0) begin
      if (idx_q < L_HDR) agg_bit = FAW[faw_i[HW-1:0]];
      else take = 1'b1;
    end else if (idx_q < L_NT) begin
      agg_bit = par_q ? is_pos : !is_neg;
    end else if (idx_q < L_HDR) begin
      if (set_q == SW'(1))      agg_bit = svc_bits[tsel];
      else if (set_q == SW'(2)) agg_bit = spare_bits[tsel];
      else take = par_q && is_neg;
    end else if (set_q == S_LAST && idx_q < L_POSE) begin
      take = !(par_q && is_pos);
    end else begin
      take = 1'b1;
    end
    if (take) agg_bit = trib_bit[tsel];
  end

  assign trib_rd = take ? (NTRIB'(1) << tsel) : '0;

  p_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(trib_rd));
  p_start_gap_r1: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> !frame_start);
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && !par_q) |=> $stable(cmd_q));
  p_negopp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q == S_LAST && idx_q >= L_NT && idx_q < L_HDR && !par_q) |-> (trib_rd == '0 && !agg_bit));

  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (frame_start) seen_q <= 1'b1;
  end

  for (genvar t = 0; t < NTRIB; t++) begin : g_cnt
    logic [9:0] rc;
    always_ff @(posedge clk) begin
      if (!rst_n || frame_start) rc <= '0;
      else rc <= rc + 10'(trib_rd[t]);
    end
    p_rd_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && seen_q) |-> (par_q ? rc == 10'd256 : (rc >= 10'd255 && rc <= 10'd257)));
  end
endmodule

// File: tb/quad_trib_mux_bench.sv
`timescale 1ns/1ps
module quad_trib_mux_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] trib_bit = 4'b0101;
  logic [7:0] just_req = 0;
  logic [3:0] svc_bits = 0, spare_bits = 0;
  logic [3:0] trib_rd;
  logic agg_bit, frame_start;

  quad_trib_mux u_quad_trib_mux (.clk(clk), .rst_n(rst_n), .trib_bit(trib_bit), .trib_rd(trib_rd),
    .just_req(just_req), .svc_bits(svc_bits), .spare_bits(spare_bits),
    .agg_bit(agg_bit), .frame_start(frame_start));

  always #2 clk = ~clk;

  int errs = 0, checks = 0;
  int m_pos = 0;
  bit m_par = 0, pend = 0;
  logic [7:0] m_cmd = 0;
  logic [15:0] lf [4] = '{16'hACE1, 16'h1234, 16'hBEEF, 16'h0F0F};
  int rdc [4] = '{0, 0, 0, 0};

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      if (errs < 30) $display("FAIL %s %s pos=%0d actual=%0d expected=%0d", tag, what, m_pos, act, exp);
    end
  endtask

  task automatic step();
    int s, i, t, er;
    bit eb;
    logic [1:0] code;
    string tag;
    if (pend) begin m_cmd = just_req; pend = 0; end
    @(negedge clk);
    s = m_pos / 264; i = m_pos % 264; t = i % 4; er = -1; eb = 0;
    code = m_cmd[2*t +: 2];
    if (s == 0 && i < 8) begin eb = (8'hE6 >> (7 - i)) & 1; tag = "R2"; end
    else if (s != 0 && i < 4) begin eb = m_par ? (code == 2'b01) : (code != 2'b10); tag = "R4"; end
    else if (s == 1 && i < 8) begin eb = svc_bits[t]; tag = "R5"; end
    else if (s == 2 && i < 8) begin eb = spare_bits[t]; tag = "R5"; end
    else if (s == 3 && i < 8) begin tag = "R8"; if (m_par && code == 2'b10) er = t; end
    else if (s == 3 && i < 12) begin tag = "R7"; if (!(m_par && code == 2'b01)) er = t; end
    else begin er = t; tag = "R3"; end
    if (er >= 0) eb = trib_bit[er];
    chk(frame_start == (m_pos == 0), "R1", "frame_start", frame_start, m_pos == 0);
    chk(agg_bit == eb, tag, "agg_bit", agg_bit, eb);
    chk(trib_rd == ((er >= 0) ? 4'(1 << er) : 4'd0), (er >= 0) ? "R9" : tag, "trib_rd",
        trib_rd, (er >= 0) ? (1 << er) : 0);
    for (int k = 0; k < 4; k++) if (trib_rd[k]) begin
      rdc[k]++;
      lf[k] = {lf[k][14:0], lf[k][15] ^ lf[k][13] ^ lf[k][12] ^ lf[k][10]};
      trib_bit[k] = lf[k][0];
    end
    if (m_pos == 1055) begin
      for (int k = 0; k < 4; k++) begin
        int e;
        e = 256;
        if (m_par && m_cmd[2*k +: 2] == 2'b01) e = 255;
        if (m_par && m_cmd[2*k +: 2] == 2'b10) e = 257;
        chk(rdc[k] == e, "R9", "reads per frame", rdc[k], e);
        rdc[k] = 0;
      end
    end
    if (m_pos == 0 && !m_par) pend = 1;
    m_pos++;
    if (m_pos == 1056) begin m_pos = 0; m_par = !m_par; end
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_pos = 0; m_par = 0; m_cmd = 0; pend = 0;
    for (int k = 0; k < 4; k++) rdc[k] = 0;
    repeat (3) @(negedge clk);
    chk(frame_start == 1, "R10", "frame_start in reset", frame_start, 1);
    chk(agg_bit == 1, "R10", "agg_bit in reset", agg_bit, 1);
    chk(trib_rd == 0, "R10", "trib_rd in reset", trib_rd, 0);
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic run_period(logic [7:0] req);
    just_req = req;
    repeat (2112) step();
  endtask

  task automatic t_none();  svc_bits = 4'b1010; spare_bits = 4'b0110; run_period(8'h00); endtask
  task automatic t_pos();   svc_bits = 4'b0011; spare_bits = 4'b1001; run_period(8'h55); endtask
  task automatic t_neg();   svc_bits = 4'b1100; spare_bits = 4'b0101; run_period(8'hAA); endtask
  task automatic t_mixed(); run_period(8'hC9); endtask

  task automatic t_late_change();
    just_req = 8'h55;
    repeat (20) step();
    just_req = 8'hAA;
    svc_bits = 4'b0111;
    repeat (2092) step();
  endtask

  task automatic t_midreset();
    just_req = 8'hAA;
    repeat (700) step();
    do_reset();
    run_period(8'h99);
  endtask

  initial begin
    #(200000 * 4);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_none();
    t_pos();
    t_neg();
    t_mixed();
    t_late_change();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule